// File: doc/BRIEF.md
# Biquinary Decade Counter With Paired Clear and Nine-Preset

This block is a 4-bit counter made of two sections that run on their own count inputs. A divide-by-2 section drives the least significant output bit. A divide-by-5 section drives the upper three output bits. Everything is synchronous to one system clock. Each section samples its count input on that clock and advances when it sees the input fall from 1 to 0.

Two pairs of control inputs override the count. Raising both inputs of the clear pair forces the outputs to 0000. Raising both inputs of the nine pair forces them to 1001. If both pairs are fully raised, the nine pair wins. A single raised input of either pair does nothing.

Linking the sections outside the block selects the count mode:
- Feeding bit 0 into the divide-by-5 count input gives a BCD decade count.
- Feeding bit 3 into the divide-by-2 count input gives a symmetric divide-by-ten code in which bit 0 is a square wave.

Top module: `bqd_counter`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls with no input activity, `q_out` is 0000. A count input that is already low when reset ends produces no count.
- R2: `q_out[0]` toggles at the first rising clock edge that samples `cnt_a_in` at 0 after the previous edge sampled it at 1. A rising `cnt_a_in` changes nothing.
- R3: On each detected falling edge of `cnt_b_in`, `q_out[3:1]` steps through 0, 1, 2, 3, 4 and then back to 0, read as a binary number.
- R4: The two sections are independent. A fall on `cnt_a_in` leaves `q_out[3:1]` unchanged, and a fall on `cnt_b_in` leaves `q_out[0]` unchanged.
- R5: Suppose `clr_a` and `clr_b` are both 1 and the nine pair is not both 1 at a clock edge. Then `q_out` is 0000 after that edge. Either clear input alone has no effect.
- R6: When `nine_a` and `nine_b` are both 1 at a clock edge, `q_out` is 1001 after that edge, whatever the clear inputs are. Either nine input alone has no effect.
- R7: Falling edges that arrive while a clear or nine override is active are ignored. Counting resumes from the forced value.
- R8: With `q_out[0]` linked to `cnt_b_in` and pulses on `cnt_a_in`, the output runs 0 to 9 as a binary number and then wraps to 0.
- R9: With `q_out[3]` linked to `cnt_a_in` and pulses on `cnt_b_in`, the output runs 0, 2, 4, 6, 8, 1, 3, 5, 7, 9 and then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_a_in | input | 1 | Count input of the divide-by-2 section |
| cnt_b_in | input | 1 | Count input of the divide-by-5 section |
| clr_a | input | 1 | Clear pair, first input |
| clr_b | input | 1 | Clear pair, second input |
| nine_a | input | 1 | Nine-preset pair, first input |
| nine_b | input | 1 | Nine-preset pair, second input |
| q_out | output | 4 | Count: bit 0 from the divide-by-2 section, bits 3..1 from the divide-by-5 section |

## Verification

**Independent sections.** A count input is raised for one clock and then dropped. The affected section changes at the edge that samples the low level, so the bench checks one cycle later, between edges.

**Overrides.** A clear or nine override takes effect at the first edge that samples the pair and is checked on the following falling clock edge.

**Linked modes.** The second section first sees the linked bit fall one edge after that bit changed. The bench therefore waits two extra clocks after each external pulse before it compares the whole output with a model-computed value.

// File: rtl/bqd_pkg.sv
package bqd_pkg;

    localparam int BIN_W   = 1;
    localparam int BIN_MOD = 2;
    localparam int QUI_W   = 3;
    localparam int QUI_MOD = 5;
    localparam int OUT_W   = BIN_W + QUI_W;
    localparam logic [OUT_W-1:0] NINE_CODE = OUT_W'(9);

    typedef logic [QUI_W-1:0] qui_t;
    typedef logic [BIN_W-1:0] bin_t;

    typedef struct packed {
        qui_t qui;
        bin_t bin;
    } bqd_state_t;

    typedef enum logic [1:0] {
        HOLD_RUN   = 2'd0,
        HOLD_CLEAR = 2'd1,
        HOLD_NINE  = 2'd2
    } force_e;

    function automatic force_e force_decode(input logic c0, input logic c1,
                                            input logic n0, input logic n1);
        if (n0 && n1)
            return HOLD_NINE;
        else if (c0 && c1)
            return HOLD_CLEAR;
        else
            return HOLD_RUN;
    endfunction

endpackage

// File: rtl/bqd_fall_detect.sv
module bqd_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= sig_in;
    end

    assign fall = prev_q & ~sig_in;

    // R2: a detected fall needs a high sample on the previous edge
    a_r2_fall_after_high: assert property (@(posedge clk) disable iff (rst)
        fall |-> $past(sig_in));

endmodule

// File: rtl/bqd_stage.sv
module bqd_stage
    import bqd_pkg::*;
#(
    parameter int W   = 3,
    parameter int MOD = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fall,
    input  force_e       frc,
    input  logic [W-1:0] preset,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt;
        unique case (frc)
            HOLD_NINE:  cnt_d = preset;
            HOLD_CLEAR: cnt_d = '0;
            default: begin
                if (fall) begin
                    if (cnt >= LAST)
                        cnt_d = '0;
                    else
                        cnt_d = cnt + W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_d;
    end

    // R3: the last state wraps to zero on a fall
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (frc == HOLD_RUN && fall && cnt == LAST) |=> (cnt == '0));

    // R3: the state never leaves the modulus range
    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R4: without a fall or an override the state holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (frc == HOLD_RUN && !fall) |=> $stable(cnt));

    // R7: an override wins over a simultaneous fall
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (frc == HOLD_CLEAR) |=> (cnt == '0));

endmodule

// File: rtl/bqd_counter.sv
module bqd_counter
    import bqd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_a_in,
    input  logic             cnt_b_in,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             nine_a,
    input  logic             nine_b,
    output logic [OUT_W-1:0] q_out
);
    logic       fall_bin;
    logic       fall_qui;
    force_e     frc;
    bqd_state_t st;
    bqd_state_t nine_st;

    assign frc     = force_decode(clr_a, clr_b, nine_a, nine_b);
    assign nine_st = bqd_state_t'(NINE_CODE);

    bqd_fall_detect u_fall_bin (
        .clk    (clk),
        .rst    (rst),
        .sig_in (cnt_a_in),
        .fall   (fall_bin)
    );

    bqd_fall_detect u_fall_qui (
        .clk    (clk),
        .rst    (rst),
        .sig_in (cnt_b_in),
        .fall   (fall_qui)
    );

    bqd_stage #(.W(BIN_W), .MOD(BIN_MOD)) u_bin (
        .clk    (clk),
        .rst    (rst),
        .fall   (fall_bin),
        .frc    (frc),
        .preset (nine_st.bin),
        .cnt    (st.bin)
    );

    bqd_stage #(.W(QUI_W), .MOD(QUI_MOD)) u_qui (
        .clk    (clk),
        .rst    (rst),
        .fall   (fall_qui),
        .frc    (frc),
        .preset (nine_st.qui),
        .cnt    (st.qui)
    );

    assign q_out = st;

    // R6: a full nine pair forces 1001 whatever the clear pair does
    a_r6_nine_wins: assert property (@(posedge clk) disable iff (rst)
        (nine_a && nine_b) |=> (q_out == 4'b1001));

    // R5: a full clear pair alone forces 0000
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_a && clr_b && !(nine_a && nine_b)) |=> (q_out == 4'b0000));

    // R1: reset leaves the count at zero
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (q_out == 4'b0000));

endmodule

// File: tb/bqd_counter_test.sv
module bqd_counter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_a = 1'b0, ext_b = 1'b0;
    logic       clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
    logic [1:0] mode = 2'd0;   // 0 independent, 1 decade, 2 biquinary
    logic       cnt_a, cnt_b;
    logic [3:0] q;
    int         tests = 0, fails = 0;
    int         cycles = 0;
    int         m_qa = 0, m_qui = 0;

    always #10 clk = ~clk;

    assign cnt_a = (mode == 2'd2) ? q[3] : ext_a;
    assign cnt_b = (mode == 2'd1) ? q[0] : ext_b;

    bqd_counter uut (
        .clk(clk), .rst(rst), .cnt_a_in(cnt_a), .cnt_b_in(cnt_b),
        .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
        .q_out(q)
    );

    function automatic int qui_next(int v);
        return (v >= 4) ? 0 : v + 1;
    endfunction

    function automatic int model_code();
        return m_qui * 2 + m_qa;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int exp);
        tests++;
        if (q !== 4'(exp)) begin
            fails++;
            $display("FAIL %s: q_out=%0d expected %0d", req, q, exp);
        end
    endtask

    task automatic pulse(logic pa, logic pb);
        ext_a = pa; ext_b = pb;
        tick();
        ext_a = 1'b0; ext_b = 1'b0;
        tick();
    endtask

    task automatic force_pair(logic c0, logic c1, logic n0, logic n1);
        clr_a = c0; clr_b = c1; nine_a = n0; nine_b = n1;
        tick();
        if (n0 && n1) begin m_qa = 1; m_qui = 4; end
        else if (c0 && c1) begin m_qa = 0; m_qui = 0; end
        clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        tick();
        check("R1 in reset", 0);
        tick();
        rst = 1'b0;
        tick();
        check("R1 after reset", 0);
        ext_a = 1'b1; tick();
        check("R2 rising input ignored", 0);
        ext_a = 1'b0; tick();
        check("R2 toggle on fall", 1);
        m_qa = 1;

        for (int i = 0; i < 6; i++) begin
            pulse(1'b0, 1'b1);
            m_qui = qui_next(m_qui);
            check("R3 quinary step", model_code());
        end
        pulse(1'b1, 1'b0);
        m_qa ^= 1;
        check("R4 bin fall keeps quinary", model_code());

        force_pair(1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 single clear ignored", model_code());
        force_pair(1'b0, 1'b0, 1'b0, 1'b1);
        check("R6 single nine ignored", model_code());
        force_pair(1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 clear pair", 0);
        force_pair(1'b1, 1'b1, 1'b1, 1'b1);
        check("R6 nine beats clear", 9);

        clr_a = 1'b1; clr_b = 1'b1;
        pulse(1'b1, 1'b1);
        check("R7 fall ignored during clear", 0);
        clr_a = 1'b0; clr_b = 1'b0; m_qa = 0; m_qui = 0;
        nine_a = 1'b1; nine_b = 1'b1;
        pulse(1'b1, 1'b1);
        check("R7 fall ignored during nine", 9);
        nine_a = 1'b0; nine_b = 1'b0; m_qa = 1; m_qui = 4;
        pulse(1'b0, 1'b1);
        m_qui = 0;
        check("R7 resume from nine", 1);

        for (int i = 0; i < 300; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 3) begin
                pulse(1'b1, 1'b0); m_qa ^= 1;
                check("R4 random bin pulse", model_code());
            end else if (sel < 6) begin
                pulse(1'b0, 1'b1); m_qui = qui_next(m_qui);
                check("R3 random quinary pulse", model_code());
            end else if (sel < 8) begin
                pulse(1'b1, 1'b1); m_qa ^= 1; m_qui = qui_next(m_qui);
                check("R4 random joint pulse", model_code());
            end else begin
                logic [3:0] r;
                r = 4'($urandom_range(0, 15));
                force_pair(r[0], r[1], r[2], r[3]);
                check("R6 random override", model_code());
            end
        end

        force_pair(1'b1, 1'b1, 1'b0, 1'b0);
        mode = 2'd1;
        tick();
        for (int k = 1; k <= 20; k++) begin
            pulse(1'b1, 1'b0);
            tick(); tick();
            check("R8 decade step", k % 10);
        end

        force_pair(1'b1, 1'b1, 1'b0, 1'b0);
        mode = 2'd2;
        tick();
        for (int k = 1; k <= 20; k++) begin
            pulse(1'b0, 1'b1);
            tick(); tick();
            check("R9 biquinary step", (k % 5) * 2 + ((k / 5) % 2));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
    end

endmodule